// File: doc/BRIEF.md
# Infrared HDLC-Style Frame Receiver

This block sits behind the clock-recovery stage of a fast infrared link and turns a recovered serial bit stream into framed payload bytes. Each accepted bit arrives as a data bit plus a one-cycle valid strobe. The receiver watches for runs of consecutive ones. A run tells it whether a zero is a stuffed bit to drop, whether the octet just seen is a boundary flag, or whether the transmitter has aborted the frame.

Opening flags are discarded, and the remaining bits are de-stuffed and packed into bytes, first-sent bit as bit 0. The final two bytes of every frame carry the frame check sequence. A three-byte hold buffer keeps them from ever reaching the byte output. At each frame end the receiver raises a one-cycle status strobe with abort, CRC error and length error indicators. While the local transmitter is active, the receive path is switched off.

Top module: `ir_hdlc_rx`

## Requirements
- R1: The octet 0x7E, received first bit first as 0,1,1,1,1,1,1,0, is a flag. Bits before the first flag are ignored. Any number of consecutive flags before a frame are discarded. A frame's bits begin after the last of them.
- R2: Inside a frame, a 0 that directly follows five consecutive 1s is removed and is not part of the payload.
- R3: A seventh consecutive 1 after payload bits ends the frame. The receiver then pulses the status strobe with abort=1 and crc_err=0 and len_err=0, marks no byte as last, and ignores bits until the next flag. A following good frame is received normally.
- R4: A flag after payload bits closes the frame. The status strobe pulses for one cycle, in the cycle after the clock edge that accepted the flag's final bit. All complete bytes except the last two are delivered in order. The last delivered byte carries byte_last_o in the same cycle as the status strobe.
- R5: Payload bits are assembled least significant bit first: the first de-stuffed bit of each byte becomes bit 0.
- R6: The CRC is the reflected CCITT CRC-16 (polynomial 0x8408 in reflected form) with a 0xFFFF preset, run over every complete and partial de-stuffed bit of the frame. crc_err is set when the final register value is not 0xF0B8.
- R7: len_err is set in any of three cases: the frame holds more than MAX_PAYLOAD payload bytes (bytes excluding the two CRC bytes), it holds fewer than two complete bytes, or its de-stuffed bit count is not a multiple of eight.
- R8: While tx_busy_i is high, bits are ignored and any partial frame is dropped without a status strobe. Reception resumes at the next flag.
- R9: Cycles with bit_vld_i low have no effect: the same frame delivered with idle gaps gives the same bytes and status.
- R10: During and right after reset, byte_vld_o, byte_last_o and the status strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Recovered line bit |
| bit_vld_i | input | 1 | bit_i is valid in this cycle |
| tx_busy_i | input | 1 | Local transmitter active; reception off |
| byte_o | output | 8 | Payload byte |
| byte_vld_o | output | 1 | byte_o valid, one cycle |
| byte_last_o | output | 1 | byte_o is the last payload byte of the frame |
| stat_vld_o | output | 1 | Frame status valid, one cycle |
| stat_abort_o | output | 1 | Frame ended by an abort run |
| stat_crc_err_o | output | 1 | CRC residue mismatch |
| stat_len_err_o | output | 1 | Length or alignment violation |

## Verification
The assertions rely on outputs moving only in response to an accepted bit. They therefore take for granted that bit_vld_i and tx_busy_i are sampled cleanly at the clock edge. They also assume that at least eight line bits separate two frame ends, which any real flag or abort run guarantees. The stimulus comes from a bench-side encoder that inserts stuffed zeros and flags the way a conforming transmitter would. Inputs change only on the falling clock edge. Abort runs and junk bits are placed so that no accidental six-ones pattern arises outside a flag.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_OPEN, ST_BODY} rx_state_e;

  typedef struct packed {
    logic data;
    logic stuff;
    logic flag;
    logic abort;
  } bit_ev_t;

  localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REF = 16'h8408;
  localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    return (c >> 1) ^ (((c[0] ^ b) == 1'b1) ? CRC_POLY_REF : 16'h0000);
  endfunction
endpackage

// File: rtl/ir_rx_run_detect.sv
module ir_rx_run_detect
  import ir_rx_pkg::*;
#(
  parameter int unsigned STUFF_RUN = 5,
  localparam int unsigned FLAG_RUN = STUFF_RUN + 1,
  localparam int unsigned SAT_RUN  = STUFF_RUN + 2,
  localparam int unsigned RUN_W    = $clog2(SAT_RUN + 1)
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    acc_i,
  input  logic    bit_i,
  input  logic    busy_i,
  output bit_ev_t ev_o
);
  localparam logic [RUN_W-1:0] STUFF_C = RUN_W'(STUFF_RUN);
  localparam logic [RUN_W-1:0] FLAG_C  = RUN_W'(FLAG_RUN);
  localparam logic [RUN_W-1:0] SAT_C   = RUN_W'(SAT_RUN);

  logic [RUN_W-1:0] ones_q;

  always_comb begin
    ev_o.stuff = acc_i & ~bit_i & (ones_q == STUFF_C);
    ev_o.flag  = acc_i & ~bit_i & (ones_q == FLAG_C);
    ev_o.abort = acc_i &  bit_i & (ones_q == FLAG_C);
    ev_o.data  = acc_i & ~ev_o.stuff & ~ev_o.flag & ~ev_o.abort
                 & ~(bit_i & (ones_q == SAT_C));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
    end else if (busy_i) begin
      ones_q <= '0;
    end else if (acc_i) begin
      if (!bit_i)               ones_q <= '0;
      else if (ones_q != SAT_C) ones_q <= ones_q + 1'b1;
    end
  end
endmodule

// File: rtl/ir_rx_bit_delay.sv
module ir_rx_bit_delay #(
  parameter int unsigned DEPTH = 7,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic push_i,
  input  logic bit_i,
  output logic pop_o,
  output logic pop_bit_o
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);

  logic [DEPTH-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;

  // bit leaves only once DEPTH younger bits prove it is not flag content
  assign pop_o     = push_i & (cnt_q == FULL_C);
  assign pop_bit_o = sr_q[DEPTH-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (push_i) begin
      sr_q <= {sr_q[DEPTH-2:0], bit_i};
      if (cnt_q != FULL_C) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ir_rx_crc.sv
module ir_rx_crc
  import ir_rx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  logic [15:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   crc_q <= CRC_PRESET;
    else if (clr_i) crc_q <= CRC_PRESET;
    else if (en_i)  crc_q <= crc_step(crc_q, bit_i);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/ir_rx_byte_asm.sv
module ir_rx_byte_asm #(
  parameter int unsigned HOLD   = 3,
  parameter int unsigned NB_MAX = 19,
  localparam int unsigned NB_W  = $clog2(NB_MAX + 1),
  localparam int unsigned HC_W  = $clog2(HOLD + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            close_i,
  input  logic            bit_vld_i,
  input  logic            bit_i,
  output logic [7:0]      byte_o,
  output logic            byte_vld_o,
  output logic            byte_last_o,
  output logic            aligned_o,
  output logic [NB_W-1:0] nbytes_o
);
  localparam logic [HC_W-1:0] HOLD_C = HC_W'(HOLD);
  localparam logic [NB_W-1:0] NBMX_C = NB_W'(NB_MAX);

  logic [6:0]      sh_q;
  logic [2:0]      bcnt_q;
  logic [7:0]      hb_q [HOLD];
  logic [HC_W-1:0] hcnt_q;
  logic [NB_W-1:0] nb_q;
  logic [7:0]      byte_q;
  logic            vld_q, last_q;
  logic            done;
  logic [7:0]      new_byte;

  assign done     = bit_vld_i & (bcnt_q == 3'd7);
  assign new_byte = {bit_i, sh_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      bcnt_q <= '0;
      hcnt_q <= '0;
      nb_q   <= '0;
      byte_q <= '0;
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      for (int i = 0; i < HOLD; i++) hb_q[i] <= '0;
    end else begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      // frame end: oldest held byte is the final payload byte
      if (close_i && hcnt_q == HOLD_C) begin
        byte_q <= hb_q[0];
        vld_q  <= 1'b1;
        last_q <= 1'b1;
      end
      if (clr_i) begin
        bcnt_q <= '0;
        hcnt_q <= '0;
        nb_q   <= '0;
      end else if (bit_vld_i) begin
        sh_q   <= {bit_i, sh_q[6:1]};
        bcnt_q <= bcnt_q + 3'd1;
        if (done) begin
          if (nb_q != NBMX_C) nb_q <= nb_q + 1'b1;
          if (hcnt_q == HOLD_C) begin
            byte_q <= hb_q[0];
            vld_q  <= 1'b1;
            for (int i = 0; i < HOLD - 1; i++) hb_q[i] <= hb_q[i+1];
            hb_q[HOLD-1] <= new_byte;
          end else begin
            hb_q[hcnt_q] <= new_byte;
            hcnt_q       <= hcnt_q + 1'b1;
          end
        end
      end
    end
  end

  assign byte_o      = byte_q;
  assign byte_vld_o  = vld_q;
  assign byte_last_o = last_q;
  assign aligned_o   = (bcnt_q == 3'd0);
  assign nbytes_o    = nb_q;
endmodule

// File: rtl/ir_hdlc_rx.sv
module ir_hdlc_rx
  import ir_rx_pkg::*;
#(
  parameter int unsigned MAX_PAYLOAD = 16,
  parameter int unsigned STUFF_RUN   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bit_i,
  input  logic       bit_vld_i,
  input  logic       tx_busy_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       byte_last_o,
  output logic       stat_vld_o,
  output logic       stat_abort_o,
  output logic       stat_crc_err_o,
  output logic       stat_len_err_o
);
  localparam int unsigned CRC_BYTES = 2;
  localparam int unsigned HOLD      = CRC_BYTES + 1;
  localparam int unsigned DLY       = STUFF_RUN + 2;
  localparam int unsigned NB_MAX    = MAX_PAYLOAD + CRC_BYTES + 1;
  localparam int unsigned NB_W      = $clog2(NB_MAX + 1);
  localparam logic [NB_W-1:0] MIN_C = NB_W'(CRC_BYTES);
  localparam logic [NB_W-1:0] TOP_C = NB_W'(MAX_PAYLOAD + CRC_BYTES);

  rx_state_e       state_q, state_d;
  bit_ev_t         ev;
  logic            acc, in_frame, push, pop, pop_bit, clr_all;
  logic            close, abort_end, aligned;
  logic [15:0]     crc;
  logic [NB_W-1:0] nbytes;
  logic            st_vld_q, st_ab_q, st_crc_q, st_len_q;

  assign acc       = bit_vld_i & ~tx_busy_i;
  assign in_frame  = (state_q != ST_HUNT);
  assign push      = ev.data & in_frame;
  assign clr_all   = tx_busy_i | ev.flag | ev.abort;
  assign close     = (state_q == ST_BODY) & ev.flag;
  assign abort_end = (state_q == ST_BODY) & ev.abort;

  ir_rx_run_detect #(.STUFF_RUN(STUFF_RUN)) u_run (
    .clk_i (clk_i), .rst_ni(rst_ni), .acc_i(acc), .bit_i(bit_i),
    .busy_i(tx_busy_i), .ev_o(ev)
  );

  ir_rx_bit_delay #(.DEPTH(DLY)) u_dly (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(clr_all), .push_i(push),
    .bit_i (bit_i), .pop_o(pop), .pop_bit_o(pop_bit)
  );

  ir_rx_crc u_crc (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_all), .en_i(pop),
    .bit_i(pop_bit), .crc_o(crc)
  );

  ir_rx_byte_asm #(.HOLD(HOLD), .NB_MAX(NB_MAX)) u_asm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_all),
    .close_i    (close),
    .bit_vld_i  (pop),
    .bit_i      (pop_bit),
    .byte_o     (byte_o),
    .byte_vld_o (byte_vld_o),
    .byte_last_o(byte_last_o),
    .aligned_o  (aligned),
    .nbytes_o   (nbytes)
  );

  always_comb begin
    state_d = state_q;
    if (tx_busy_i)     state_d = ST_HUNT;
    else if (ev.abort) state_d = ST_HUNT;
    else if (ev.flag)  state_d = ST_OPEN;
    else if (pop)      state_d = ST_BODY;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      st_vld_q <= 1'b0;
      st_ab_q  <= 1'b0;
      st_crc_q <= 1'b0;
      st_len_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      st_vld_q <= close | abort_end;
      st_ab_q  <= abort_end;
      st_crc_q <= close & (crc != CRC_RESIDUE);
      st_len_q <= close & (~aligned | (nbytes < MIN_C) | (nbytes > TOP_C));
    end
  end

  assign stat_vld_o     = st_vld_q;
  assign stat_abort_o   = st_ab_q;
  assign stat_crc_err_o = st_crc_q;
  assign stat_len_err_o = st_len_q;
endmodule

// File: rtl/ir_hdlc_rx_chk.sv
module ir_hdlc_rx_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic bit_vld_i,
  input logic tx_busy_i,
  input logic byte_vld_o,
  input logic byte_last_o,
  input logic stat_vld_o,
  input logic stat_abort_o,
  input logic stat_crc_err_o,
  input logic stat_len_err_o
);
  AST_LAST_HAS_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_last_o |-> byte_vld_o); // R4
  AST_LAST_WITH_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_last_o |-> stat_vld_o && !stat_abort_o); // R4
  AST_STAT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_vld_o |=> !stat_vld_o); // R4
  AST_ABORT_ALONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_abort_o |-> stat_vld_o && !stat_crc_err_o && !stat_len_err_o && !byte_last_o); // R3
  AST_CRC_IN_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_crc_err_o |-> stat_vld_o); // R6
  AST_LEN_IN_STAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_len_err_o |-> stat_vld_o); // R7
  AST_BUSY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_busy_i |=> !byte_vld_o && !stat_vld_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_vld_i |=> !byte_vld_o && !stat_vld_o); // R9
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !byte_vld_o && !stat_vld_o); // R10
endmodule

bind ir_hdlc_rx ir_hdlc_rx_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bit_vld_i     (bit_vld_i),
  .tx_busy_i     (tx_busy_i),
  .byte_vld_o    (byte_vld_o),
  .byte_last_o   (byte_last_o),
  .stat_vld_o    (stat_vld_o),
  .stat_abort_o  (stat_abort_o),
  .stat_crc_err_o(stat_crc_err_o),
  .stat_len_err_o(stat_len_err_o)
);

// File: tb/test_ir_hdlc_rx.sv
module test_ir_hdlc_rx;
  localparam int MAXP = 16;
  localparam int NV   = 8;
  // {len, seed, kind(0 good,1 bad fcs,3 extra bits), opening flags, exp crc_err, exp len_err}
  localparam logic [25:0] VEC [NV] = '{
    {8'd4,  8'd1, 4'd0, 4'd1, 1'b0, 1'b0},
    {8'd1,  8'd2, 4'd0, 4'd3, 1'b0, 1'b0},
    {8'd16, 8'd3, 4'd0, 4'd1, 1'b0, 1'b0},
    {8'd17, 8'd4, 4'd0, 4'd2, 1'b0, 1'b1},
    {8'd5,  8'd5, 4'd1, 4'd1, 1'b1, 1'b0},
    {8'd3,  8'd6, 4'd3, 4'd1, 1'b1, 1'b1},
    {8'd0,  8'd7, 4'd0, 4'd1, 1'b0, 1'b0},
    {8'd9,  8'd8, 4'd0, 4'd4, 1'b0, 1'b0}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bit_i = 1'b0, bit_vld_i = 1'b0, tx_busy_i = 1'b0;
  logic [7:0] byte_o;
  logic byte_vld_o, byte_last_o, stat_vld_o, stat_abort_o, stat_crc_err_o, stat_len_err_o;

  always #5 clk = ~clk;

  ir_hdlc_rx #(.MAX_PAYLOAD(MAXP)) i_ir_hdlc_rx (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .bit_vld_i(bit_vld_i),
    .tx_busy_i(tx_busy_i), .byte_o(byte_o), .byte_vld_o(byte_vld_o),
    .byte_last_o(byte_last_o), .stat_vld_o(stat_vld_o), .stat_abort_o(stat_abort_o),
    .stat_crc_err_o(stat_crc_err_o), .stat_len_err_o(stat_len_err_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] got [64];
  int n_got, n_stat, last_cnt, last_idx, last_ws;
  logic st_ab, st_crc, st_len;
  logic [7:0] fb [40];
  int fn, ones_tx, gap_mode, gap_ctr;

  always @(negedge clk) begin
    if (byte_vld_o) begin
      if (n_got < 64) got[n_got] = byte_o;
      if (byte_last_o) begin last_cnt++; last_idx = n_got; end
      n_got++;
    end
    if (stat_vld_o) begin
      n_stat++;
      st_ab = stat_abort_o; st_crc = stat_crc_err_o; st_len = stat_len_err_o;
      if (byte_last_o) last_ws++;
    end
  end

  task automatic clear_mon();
    @(posedge clk); #1;
    n_got = 0; n_stat = 0; last_cnt = 0; last_idx = -1; last_ws = 0;
    st_ab = 0; st_crc = 0; st_len = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_bit(logic [15:0] c, logic b);
    crc_bit = (c >> 1) ^ ((c[0] ^ b) ? 16'h8408 : 16'h0);
  endfunction

  function automatic logic [15:0] crc_bytes(int n);
    logic [15:0] c = 16'hFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) c = crc_bit(c, fb[i][k]);
    return c;
  endfunction

  task automatic send_bit(input logic b);
    if (gap_mode != 0) begin
      gap_ctr++;
      if (gap_ctr % 3 == 1) begin @(negedge clk); bit_vld_i = 1'b0; end
    end
    @(negedge clk);
    bit_i = b; bit_vld_i = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); bit_vld_i = 1'b0; end
  endtask

  task automatic send_flag();
    for (int k = 0; k < 8; k++) send_bit(k != 0 && k != 7);
  endtask

  task automatic send_dbit(input logic b);
    send_bit(b);
    if (b) begin
      ones_tx++;
      if (ones_tx == 5) begin send_bit(1'b0); ones_tx = 0; end
    end else ones_tx = 0;
  endtask

  task automatic send_dbyte(input logic [7:0] v);
    for (int k = 0; k < 8; k++) send_dbit(v[k]);
  endtask

  task automatic build(input int len, input int seed, input int kind);
    logic [15:0] fcs;
    fn = 0;
    for (int i = 0; i < len; i++) begin
      if (i % 3 == 1)      fb[fn] = 8'hFF;
      else if (i % 5 == 2) fb[fn] = 8'h7E;
      else                 fb[fn] = 8'(seed * 17 + i * 45);
      fn++;
    end
    fcs = ~crc_bytes(fn);
    fb[fn] = fcs[7:0]; fb[fn+1] = fcs[15:8]; fn += 2;
    if (kind == 1) fb[fn-1] ^= 8'h01;
  endtask

  task automatic send_frame(input int nfl, input bit extra);
    for (int f = 0; f < nfl; f++) send_flag();
    ones_tx = 0;
    for (int i = 0; i < fn; i++) send_dbyte(fb[i]);
    if (extra) begin send_dbit(1'b1); send_dbit(1'b0); send_dbit(1'b1); end
    send_flag();
    idle(4);
  endtask

  task automatic check_frame(input string req, input int nb, input int ab, input int ce, input int le);
    int exp_last;
    chk({req, " byte count"}, n_got, nb);
    for (int i = 0; i < nb && i < 64; i++) chk("R2 R5 payload byte", got[i], fb[i]);
    chk("R4 status strobe count", n_stat, 1);
    chk("R3 abort flag", st_ab, ab);
    chk("R6 crc flag", st_crc, ce);
    chk("R7 length flag", st_len, le);
    exp_last = (nb > 0 && ab == 0) ? 1 : 0;
    chk("R4 last marker count", last_cnt, exp_last);
    chk("R4 last with status", last_ws, exp_last);
    if (exp_last != 0) chk("R4 last position", last_idx, nb - 1);
  endtask

  task automatic good_frame(input string req, input int len, input int seed);
    clear_mon();
    build(len, seed, 0);
    send_frame(1, 1'b0);
    check_frame(req, len, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    gap_mode = 0; gap_ctr = 0; ones_tx = 0;
    n_got = 0; n_stat = 0; last_cnt = 0; last_idx = -1; last_ws = 0;
    repeat (3) @(negedge clk);
    chk("R10 byte_vld in reset", byte_vld_o, 0);
    chk("R10 stat_vld in reset", stat_vld_o, 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 byte_vld after reset", byte_vld_o, 0);
    chk("R10 byte_last after reset", byte_last_o, 0);
    chk("R10 stat_vld after reset", stat_vld_o, 0);

    // R1: junk and a long ones run before the first flag
    clear_mon();
    for (int k = 0; k < 7; k++) send_bit(k[0] ^ k[2]);
    for (int k = 0; k < 9; k++) send_bit(1'b1);
    build(6, 9, 0);
    send_frame(2, 1'b0);
    check_frame("R1 junk prefix", 6, 0, 0, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      int len, seed, kind, nfl, ec, el, nb;
      len = int'(VEC[v][25:18]); seed = int'(VEC[v][17:10]);
      kind = int'(VEC[v][9:6]); nfl = int'(VEC[v][5:2]);
      ec = int'(VEC[v][1]); el = int'(VEC[v][0]);
      clear_mon();
      build(len, seed, kind);
      send_frame(nfl, kind == 3);
      nb = (fn >= 3) ? fn - 2 : 0;
      check_frame("R1 R4 R7 vector", nb, 0, ec, el);
    end

    // R3: abort after six bytes; last byte ends in 0 so the run is pure
    clear_mon();
    build(6, 11, 0);
    fb[5] = 8'h3C;
    send_flag();
    ones_tx = 0;
    for (int i = 0; i < 6; i++) send_dbyte(fb[i]);
    for (int k = 0; k < 8; k++) send_bit(1'b1);
    idle(4);
    check_frame("R3 abort", 2, 1, 0, 0);
    good_frame("R3 recovery", 5, 12);

    // R8: transmitter becomes busy mid-frame
    clear_mon();
    build(7, 13, 0);
    send_flag();
    ones_tx = 0;
    for (int i = 0; i < 3; i++) send_dbyte(fb[i]);
    @(negedge clk); tx_busy_i = 1'b1;
    for (int i = 3; i < 5; i++) send_dbyte(fb[i]);
    @(negedge clk); tx_busy_i = 1'b0;
    for (int i = 5; i < fn; i++) send_dbyte(fb[i]);
    send_flag();
    idle(4);
    chk("R8 no bytes while dropped", n_got, 0);
    chk("R8 no status while dropped", n_stat, 0);
    good_frame("R8 recovery", 4, 14);

    // R7: frame shorter than the CRC
    clear_mon();
    fb[0] = 8'h12; fn = 1;
    send_frame(1, 1'b0);
    check_frame("R7 short frame", 0, 0, (crc_bytes(1) != 16'hF0B8) ? 1 : 0, 1);

    // R9: idle gaps between accepted bits
    gap_mode = 1;
    good_frame("R9 gapped", 8, 15);
    gap_mode = 0;

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule